// File: doc/BRIEF.md
# Radio-State Driven GPIO Bank

This block is a small bank of general-purpose pins that software configures through a register write port. Each port write carries a data word and a bit mask. Each pin either follows a software-written manual level or is handed to hardware. Under hardware control, the level is taken from one of four state registers. The choice among them comes from the live transmit-active and receive-active status of the radio.

Hardware-controlled pins switch on their own when the radio changes state, so an external amplifier or switch moves together with the rest of the radio. No software is involved in that switching. Software still sets each pin's direction and can read the pins back through a two-flop synchronizer.

Top module: `atr_gpio_bank`

## Requirements
- R1: Control register (address 0) bit i selects the source of `pin_out[i]`: 1 takes the state-selected register, 0 takes the manual output register.
- R2: `pin_oe[i]` equals direction register (address 1) bit i, where 1 is output and 0 is input, whatever the control bit says. It changes only after a direction write.
- R3: A pin under manual control drives the matching bit of the manual output register (address 2).
- R4: The state index is {tx_active, rx_active}. 00 selects the idle register (address 3), 01 the receive register (address 4), 10 the transmit register (address 5) and 11 the full-duplex register (address 6).
- R5: A write changes only the bits set in `wr_mask`. All other bits of the addressed register keep their contents.
- R6: `pin_out` is registered. It reflects the status inputs and register contents present at the previous rising edge. A register write therefore reaches `pin_out` two edges after it is presented.
- R7: Reset (active-low `rst_n`) clears every register, `pin_out` and `pin_oe`. Every pin becomes a manually controlled input.
- R8: Address 7 reads `pin_in` through two flops, so a change shows after two rising edges. Writes to address 7 have no effect.
- R9: `rd_data` combinationally returns the stored contents of the register at `rd_addr` for addresses 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | PIN_W | Write value |
| wr_mask | input | PIN_W | Per-bit write enable |
| rd_addr | input | 3 | Read address |
| rd_data | output | PIN_W | Read value |
| tx_active | input | 1 | Radio transmitting |
| rx_active | input | 1 | Radio receiving |
| pin_in | input | PIN_W | Pin levels from pads |
| pin_out | output | PIN_W | Pin levels to pads |
| pin_oe | output | PIN_W | Per-pin output enable |

## Verification
A software write to a state register and a radio state change can land in the same clock cycle. The bench provokes this by moving the status inputs to idle in the same cycle that it rewrites the idle register. It then expects the first edge to show the old idle value and the second edge the new one. A masked write to the manual output register is also made while state-driven pins are active. This confirms that the manual bits change and the state-driven bits do not.

// File: rtl/atr_gpio_bank.sv
module atr_gpio_bank #(
  parameter int PIN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [PIN_W-1:0] wr_data,
  input  logic [PIN_W-1:0] wr_mask,
  input  logic [2:0]       rd_addr,
  output logic [PIN_W-1:0] rd_data,
  input  logic             tx_active,
  input  logic             rx_active,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe
);
  localparam logic [2:0] A_CTRL = 3'd0, A_DIR = 3'd1, A_MAN = 3'd2, A_IDLE = 3'd3,
                         A_RX = 3'd4, A_TX = 3'd5, A_FDX = 3'd6;

  logic [PIN_W-1:0] ctrl_q, dir_q, man_q, idle_q, rxv_q, txv_q, fdx_q;
  logic [PIN_W-1:0] sync1_q, sync2_q, state_val, next_out;

  function automatic logic [PIN_W-1:0] merge(input logic [PIN_W-1:0] old_v,
                                             input logic [PIN_W-1:0] new_v,
                                             input logic [PIN_W-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; dir_q <= '0; man_q <= '0;
      idle_q <= '0; rxv_q <= '0; txv_q <= '0; fdx_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_q <= merge(ctrl_q, wr_data, wr_mask);
        A_DIR:  dir_q  <= merge(dir_q,  wr_data, wr_mask);
        A_MAN:  man_q  <= merge(man_q,  wr_data, wr_mask);
        A_IDLE: idle_q <= merge(idle_q, wr_data, wr_mask);
        A_RX:   rxv_q  <= merge(rxv_q,  wr_data, wr_mask);
        A_TX:   txv_q  <= merge(txv_q,  wr_data, wr_mask);
        A_FDX:  fdx_q  <= merge(fdx_q,  wr_data, wr_mask);
        default: ;
      endcase
    end
  end

  always_comb begin
    case ({tx_active, rx_active})
      2'b00:   state_val = idle_q;
      2'b01:   state_val = rxv_q;
      2'b10:   state_val = txv_q;
      default: state_val = fdx_q;
    endcase
  end

  assign next_out = (ctrl_q & state_val) | (~ctrl_q & man_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      pin_out <= next_out;
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_oe = dir_q;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_DIR:   rd_data = dir_q;
      A_MAN:   rd_data = man_q;
      A_IDLE:  rd_data = idle_q;
      A_RX:    rd_data = rxv_q;
      A_TX:    rd_data = txv_q;
      A_FDX:   rd_data = fdx_q;
      default: rd_data = sync2_q;
    endcase
  end

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_DIR) |=> $stable(pin_oe)); // R2
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL) |=> ((ctrl_q & ~$past(wr_mask)) == ($past(ctrl_q) & ~$past(wr_mask)))); // R5
  AST_MANUAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out & ~$past(ctrl_q)) == ($past(man_q) & ~$past(ctrl_q)))); // R3
  AST_IDLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rx_active) |=> ((pin_out & $past(ctrl_q)) == ($past(idle_q) & $past(ctrl_q)))); // R4
  AST_FDX_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && rx_active) |=> ((pin_out & $past(ctrl_q)) == ($past(fdx_q) & $past(ctrl_q)))); // R4
endmodule

// File: tb/atr_gpio_bank_tb.sv
module atr_gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIN_W = 6;
  localparam int NVEC = 8;
  // each entry: {tx, rx, expected pin_out}
  localparam logic [7:0] VEC [NVEC] = '{
    {2'b00, 6'h21}, {2'b01, 6'h22}, {2'b10, 6'h24}, {2'b11, 6'h28},
    {2'b01, 6'h22}, {2'b00, 6'h21}, {2'b11, 6'h28}, {2'b10, 6'h24}};

  logic clk = 0, rst_n = 0, wr_en = 0, tx_active = 0, rx_active = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [PIN_W-1:0] wr_data = '0, wr_mask = '0, pin_in = '0;
  logic [PIN_W-1:0] rd_data, pin_out, pin_oe;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atr_gpio_bank #(.PIN_W(PIN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data), .tx_active(tx_active),
    .rx_active(rx_active), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string req, input logic [PIN_W-1:0] act, input logic [PIN_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [PIN_W-1:0] d, input logic [PIN_W-1:0] m);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [PIN_W-1:0] exp);
    rd_addr = a; #1; check(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 pin_out", pin_out, '0);
    check("R7 pin_oe", pin_oe, '0);
    for (int a = 0; a < 8; a++) rd_check("R7 reg", 3'(a), '0);

    wr(3'd0, 6'h3F, 6'h0F);
    wr(3'd0, 6'h00, 6'h30);
    rd_check("R5 ctrl masked", 3'd0, 6'h0F);
    wr(3'd1, 6'h3E, 6'h3F);
    check("R2 oe follows dir, ATR input pin0 off", pin_oe, 6'h3E);
    wr(3'd2, 6'h20, 6'h3F);
    wr(3'd3, 6'h31, 6'h3F);
    wr(3'd4, 6'h12, 6'h3F);
    wr(3'd5, 6'h04, 6'h3F);
    wr(3'd6, 6'h38, 6'h3F);
    rd_check("R9 fdx readback", 3'd6, 6'h38);
    rd_check("R9 man readback", 3'd2, 6'h20);

    foreach (VEC[i]) begin
      @(negedge clk); {tx_active, rx_active} = VEC[i][7:6];
      @(negedge clk);
      check("R4 R1 R3 state pick", pin_out, VEC[i][5:0]);
    end

    @(negedge clk); {tx_active, rx_active} = 2'b11; #1;
    check("R6 no change before edge", pin_out, 6'h24);
    @(negedge clk);
    check("R6 change after one edge", pin_out, 6'h28);

    @(negedge clk); {tx_active, rx_active} = 2'b00;
    wr_en = 1; wr_addr = 3'd3; wr_data = 6'h03; wr_mask = 6'h0F;
    @(negedge clk); wr_en = 0;
    check("R6 same-cycle write old value", pin_out, 6'h21);
    @(negedge clk);
    check("R6 same-cycle write new value", pin_out, 6'h23);

    wr(3'd2, 6'h10, 6'h30);
    @(negedge clk);
    check("R3 manual bits change only", pin_out, 6'h13);
    check("R2 oe unchanged", pin_oe, 6'h3E);

    rd_addr = 3'd7;
    @(negedge clk); pin_in = 6'h2A;
    @(negedge clk); #1;
    check("R8 one edge not yet", rd_data, 6'h00);
    @(negedge clk); #1;
    check("R8 two edges", rd_data, 6'h2A);
    wr(3'd7, 6'h3F, 6'h3F);
    rd_check("R8 write ignored", 3'd7, 6'h2A);
    rd_check("R8 ctrl untouched", 3'd0, 6'h0F);
    check("R8 pins untouched", pin_out, 6'h13);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule